// File: doc/BRIEF.md
# Banked Register Window Controller

This block is the host-facing register front end of a peripheral whose registers are spread over up to eight banks. All of them share one three-bit address window. Address 7 is always the control register. Its low three bits choose the bank that addresses 0 to 6 reach. Its upper bits control power down, a global interrupt gate, an error-state clear and a full soft reset.

Bank 0 holds a sticky status byte, the per-source interrupt enables and three count registers. Bank 1 holds a legacy configuration byte and a half-duplex timeout, and the rest of that bank is plain storage. Banks 2 and above are plain storage. The error clear wipes only the status and the counts. The soft reset wipes everything except the lower seven bits of the legacy byte and the timeout. The control register stays reachable in power down, so software can always leave that mode.

Top module: `banked_regwin`

## Requirements
- R1: After rst_n is released, the control register at address 7 reads 0x00, bank 0 is selected and irq is low whatever irq_req is.
- R2: A write to address 7 stores wdata[2:0] as the bank number. Reads and writes at addresses 0 to 6 then reach the selected bank, and each bank keeps its own contents.
- R3: While cs_n is low, address 7 reaches the control register whatever bank is selected. It reads back bit 7 as power down, bit 5 as interrupt enable and bits 2:0 as the bank number, and bits 6, 4 and 3 always read 0.
- R4: In bank 0, address 0 is a status byte. Each bit is set by a high stat_evt bit, holds until cleared, and ignores host writes. Address 1 holds the interrupt enables. Addresses 2, 3 and 4 are read/write count registers. Addresses 5 and 6 read 0x00.
- R5: In bank 1, address 0 is the legacy byte and address 1 is the timeout byte. Addresses 2 to 6, and all addresses of banks 2 to 7, are read/write storage.
- R6: A control write with bit 4 set clears the bank 0 status byte and the three count registers at that clock edge and leaves every other register unchanged. A stat_evt bit that is high in the same cycle still ends up set.
- R7: irq is high exactly when control bit 5 is set and some bit i has irq_req[i] and enable bit i both set.
- R8: A control write with bit 6 set returns every register to its reset value at that clock edge, including the control register itself. The exceptions are legacy bits 6:0 and the timeout byte, which keep their values. Bit 6 then reads 0.
- R9: While control bit 7 is set, reads of addresses 0 to 6 return 0x00 and writes to them are ignored, while address 7 stays readable and writable. Clearing bit 7 brings back the earlier contents.
- R10: While cs_n is high no write takes effect, and rdata is 0x00 whenever cs_n is high or rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 3 | Window address; 7 is the control register |
| rd | input | 1 | Read strobe; rdata is valid in the same cycle |
| wr | input | 1 | Write strobe; data is taken at the next rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not reading |
| stat_evt | input | 8 | Status event pulses that set the bank 0 status bits |
| irq_req | input | IRQ_W | Per-source interrupt requests |
| irq | output | 1 | Gated interrupt output |

## Verification
The hardest case to reach is a soft reset that lands while the legacy byte, the timeout and the storage banks all hold known non-zero values. Only then does the difference between cleared and preserved registers show at rdata. The bench loads these registers in directed writes, first with power down off and then with it set, and issues the reset. It then walks every bank and checks each one against its own model. Random control writes include an occasional soft reset and frequent power-down toggles, so the model and the design must agree after these events in many different register states.

// File: rtl/banked_regwin_pkg.sv
package banked_regwin_pkg;
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned ADDR_W    = 3;
   localparam int unsigned BANK_W    = 3;
   localparam int unsigned MAX_BANKS = 1 << BANK_W;
   localparam int unsigned WIN_DEPTH = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(WIN_DEPTH);

   localparam int PD_BIT   = 7;
   localparam int MRST_BIT = 6;
   localparam int MIE_BIT  = 5;
   localparam int ERST_BIT = 4;

   typedef struct packed {
      logic              pd;
      logic              mie;
      logic [BANK_W-1:0] bank;
   } ctrl_t;

   function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
      logic [DATA_W-1:0] v;
      v             = '0;
      v[PD_BIT]     = c.pd;
      v[MIE_BIT]    = c.mie;
      v[BANK_W-1:0] = c.bank;
      return v;
   endfunction
endpackage

// File: rtl/rw_scratch.sv
module rw_scratch
   import banked_regwin_pkg::*;
#(
   parameter int unsigned LO_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (LO_ADDR >= WIN_DEPTH) begin : g_bad
         $error("rw_scratch: LO_ADDR must be below the window depth");
      end
   endgenerate

   logic [DATA_W-1:0] mem [LO_ADDR:WIN_DEPTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = LO_ADDR; i < WIN_DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = LO_ADDR; i < WIN_DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         for (int i = LO_ADDR; i < WIN_DEPTH; i++)
            if (addr == ADDR_W'(i)) mem[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = LO_ADDR; i < WIN_DEPTH; i++)
         if (addr == ADDR_W'(i)) rdata = mem[i];
   end
endmodule

// File: rtl/rw_bank0.sv
module rw_bank0
   import banked_regwin_pkg::*;
#(
   parameter int unsigned IRQ_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              clr_err,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] stat_evt,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] status,
   output logic [IRQ_W-1:0]  ien
);
   generate
      if (IRQ_W < 1 || IRQ_W > DATA_W) begin : g_bad
         $error("rw_bank0: IRQ_W must lie in 1..DATA_W");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_MEM  = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(4);

   logic [DATA_W-1:0] stat_q, ien_q, msg_q, mem_q, byte_q;
   logic [DATA_W-1:0] stat_base;

   assign stat_base = (clr_all || clr_err) ? '0 : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_base | stat_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         msg_q  <= '0;
         mem_q  <= '0;
         byte_q <= '0;
      end else if (clr_all) begin
         ien_q  <= '0;
         msg_q  <= '0;
         mem_q  <= '0;
         byte_q <= '0;
      end else if (clr_err) begin
         msg_q  <= '0;
         mem_q  <= '0;
         byte_q <= '0;
      end else if (we) begin
         case (addr)
            A_IEN:   ien_q  <= wdata;
            A_MSG:   msg_q  <= wdata;
            A_MEM:   mem_q  <= wdata;
            A_BYTE:  byte_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         A_STAT:  rdata = stat_q;
         A_IEN:   rdata = ien_q;
         A_MSG:   rdata = msg_q;
         A_MEM:   rdata = mem_q;
         A_BYTE:  rdata = byte_q;
         default: rdata = '0;
      endcase
   end

   assign status = stat_q;
   assign ien    = ien_q[IRQ_W-1:0];
endmodule

// File: rtl/rw_bank1.sv
module rw_bank1
   import banked_regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] legacy,
   output logic [DATA_W-1:0] timeout
);
   localparam logic [ADDR_W-1:0] A_LEG = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_TMO = ADDR_W'(1);
   localparam int unsigned       SCR_LO = 2;

   logic [DATA_W-1:0] leg_q, tmo_q, scr_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         leg_q <= '0;
         tmo_q <= '0;
      end else if (clr_all) begin
         leg_q[DATA_W-1] <= 1'b0;
      end else if (we) begin
         if (addr == A_LEG) leg_q <= wdata;
         if (addr == A_TMO) tmo_q <= wdata;
      end
   end

   rw_scratch #(.LO_ADDR(SCR_LO)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .rdata (scr_rd)
   );

   always_comb begin
      case (addr)
         A_LEG:   rdata = leg_q;
         A_TMO:   rdata = tmo_q;
         default: rdata = scr_rd;
      endcase
   end

   assign legacy  = leg_q;
   assign timeout = tmo_q;
endmodule

// File: rtl/banked_regwin.sv
module banked_regwin
   import banked_regwin_pkg::*;
#(
   parameter int unsigned NBANKS = 8,
   parameter int unsigned IRQ_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] stat_evt,
   input  logic [IRQ_W-1:0]  irq_req,
   output logic              irq
);
   generate
      if (NBANKS < 2 || NBANKS > MAX_BANKS) begin : g_bad_banks
         $error("banked_regwin: NBANKS must lie in 2..8");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] ctrl_byte;
   logic              access, ctrl_wr, mrst, erst, win_wr;
   logic [DATA_W-1:0] bank_rd [MAX_BANKS];
   logic [MAX_BANKS-1:0] bank_we;
   logic [IRQ_W-1:0]  ien;
   logic [DATA_W-1:0] line_stat, legacy_q, timeout_q;

   assign access  = !cs_n;
   assign ctrl_wr = access && wr && (addr == CTRL_ADDR);
   assign mrst    = ctrl_wr && wdata[MRST_BIT];
   assign erst    = ctrl_wr && wdata[ERST_BIT] && !wdata[MRST_BIT];
   assign win_wr  = access && wr && (addr != CTRL_ADDR) && !ctrl_q.pd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (mrst) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.pd   <= wdata[PD_BIT];
         ctrl_q.mie  <= wdata[MIE_BIT];
         ctrl_q.bank <= wdata[BANK_W-1:0];
      end
   end

   assign ctrl_byte = ctrl_pack(ctrl_q);

   generate
      for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
         assign bank_we[b] = win_wr && (ctrl_q.bank == BANK_W'(b));
         if (b == 0) begin : g_b0
            rw_bank0 #(.IRQ_W(IRQ_W)) u_b0 (
               .clk      (clk),
               .rst_n    (rst_n),
               .clr_all  (mrst),
               .clr_err  (erst),
               .we       (bank_we[b]),
               .addr     (addr),
               .wdata    (wdata),
               .stat_evt (stat_evt),
               .rdata    (bank_rd[b]),
               .status   (line_stat),
               .ien      (ien)
            );
         end else if (b == 1) begin : g_b1
            rw_bank1 u_b1 (
               .clk     (clk),
               .rst_n   (rst_n),
               .clr_all (mrst),
               .we      (bank_we[b]),
               .addr    (addr),
               .wdata   (wdata),
               .rdata   (bank_rd[b]),
               .legacy  (legacy_q),
               .timeout (timeout_q)
            );
         end else if (b < NBANKS) begin : g_plain
            rw_scratch #(.LO_ADDR(0)) u_scr (
               .clk   (clk),
               .rst_n (rst_n),
               .clr   (mrst),
               .we    (bank_we[b]),
               .addr  (addr),
               .wdata (wdata),
               .rdata (bank_rd[b])
            );
         end else begin : g_absent
            assign bank_rd[b] = '0;
         end
      end
   endgenerate

   always_comb begin
      if (!(access && rd))        rdata = '0;
      else if (addr == CTRL_ADDR) rdata = ctrl_byte;
      else if (ctrl_q.pd)         rdata = '0;
      else                        rdata = bank_rd[ctrl_q.bank];
   end

   assign irq = ctrl_q.mie && |(irq_req & ien);
endmodule

// File: rtl/banked_regwin_chk.sv
module banked_regwin_chk
   import banked_regwin_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rd,
   input logic              wr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] stat_evt,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl_byte,
   input logic [DATA_W-1:0] line_stat,
   input logic [DATA_W-1:0] legacy_q,
   input logic [DATA_W-1:0] timeout_q
);
   logic ctl_write, win_write;
   assign ctl_write = !cs_n && wr && (addr == CTRL_ADDR);
   assign win_write = !cs_n && wr && (addr != CTRL_ADDR);

   // R8
   mrst_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_write && wdata[MRST_BIT]) |=> (ctrl_byte == '0));

   // R8
   mrst_keeps_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_write && wdata[MRST_BIT]) |=>
         (legacy_q[DATA_W-2:0] == $past(legacy_q[DATA_W-2:0])) && $stable(timeout_q));

   // R6
   erst_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_write && wdata[ERST_BIT]) |=> (line_stat == $past(stat_evt)));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[MIE_BIT] |-> !irq);

   // R9
   pd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[PD_BIT] && !cs_n && rd && addr != CTRL_ADDR) |-> (rdata == '0));

   // R9
   pd_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[PD_BIT] && win_write) |=> ($stable(legacy_q) && $stable(timeout_q)));

   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !rd) |-> (rdata == '0));

   // R3
   ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_write |=> $stable(ctrl_byte));
endmodule

bind banked_regwin banked_regwin_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .addr      (addr),
   .rd        (rd),
   .wr        (wr),
   .wdata     (wdata),
   .rdata     (rdata),
   .stat_evt  (stat_evt),
   .irq       (irq),
   .ctrl_byte (ctrl_byte),
   .line_stat (line_stat),
   .legacy_q  (legacy_q),
   .timeout_q (timeout_q)
);

// File: tb/banked_regwin_test.sv
`timescale 1ns/1ps
module banked_regwin_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic [2:0] addr = '0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] stat_evt = '0;
   logic [7:0] irq_req = '0;
   logic       irq;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2.5 clk = ~clk;

   banked_regwin #(.NBANKS(8), .IRQ_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rdata(rdata), .stat_evt(stat_evt), .irq_req(irq_req), .irq(irq)
   );

   // reference model
   logic [7:0] m_ctrl, m_stat, m_ien, m_leg, m_tmo;
   logic [7:0] m_cnt [3];
   logic [7:0] m_scr [8][8];

   task automatic model_reset(input bit keep_special);
      m_ctrl = '0; m_stat = '0; m_ien = '0;
      for (int i = 0; i < 3; i++) m_cnt[i] = '0;
      for (int b = 0; b < 8; b++) for (int a = 0; a < 8; a++) m_scr[b][a] = '0;
      if (keep_special) m_leg[7] = 1'b0;
      else begin m_leg = '0; m_tmo = '0; end
   endtask

   task automatic model_write(input logic [2:0] a, input logic [7:0] d);
      logic [2:0] b;
      b = m_ctrl[2:0];
      if (a == 3'd7) begin
         if (d[6]) model_reset(1'b1);
         else begin
            if (d[4]) begin m_stat = '0; for (int i = 0; i < 3; i++) m_cnt[i] = '0; end
            m_ctrl = {d[7], 1'b0, d[5], 2'b00, d[2:0]};
         end
      end else if (!m_ctrl[7]) begin
         if (b == 3'd0) begin
            if (a == 3'd1) m_ien = d;
            else if (a >= 3'd2 && a <= 3'd4) m_cnt[a-2] = d;
         end else if (b == 3'd1 && a == 3'd0) m_leg = d;
         else if (b == 3'd1 && a == 3'd1) m_tmo = d;
         else m_scr[b][a] = d;
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [2:0] a);
      logic [2:0] b;
      b = m_ctrl[2:0];
      if (a == 3'd7) return m_ctrl;
      if (m_ctrl[7]) return 8'h00;
      if (b == 3'd0) begin
         case (a)
            3'd0: return m_stat;
            3'd1: return m_ien;
            3'd2, 3'd3, 3'd4: return m_cnt[a-2];
            default: return 8'h00;
         endcase
      end
      if (b == 3'd1 && a == 3'd0) return m_leg;
      if (b == 3'd1 && a == 3'd1) return m_tmo;
      return m_scr[b][a];
   endfunction

   function automatic logic exp_irq(input logic [7:0] req);
      return m_ctrl[5] && |(req & m_ien);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a);
      @(negedge clk);
      cs_n = 1'b0; rd = 1'b1; addr = a;
      #1 chk(req, rdata, exp_read(a));
      cs_n = 1'b1; rd = 1'b0;
   endtask

   task automatic irq_chk(input string req, input logic [7:0] r);
      @(negedge clk);
      irq_req = r;
      #1 chk(req, {7'b0, irq}, {7'b0, exp_irq(r)});
   endtask

   task automatic pulse_evt(input logic [7:0] v);
      @(negedge clk);
      stat_evt = v;
      @(negedge clk);
      stat_evt = '0;
      m_stat = m_stat | v;
   endtask

   task automatic sweep(input string req);
      for (int b = 0; b < 8; b++) begin
         do_write(3'd7, 8'(b));
         for (int a = 0; a < 7; a++) rd_chk(req, 3'(a));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset(1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_chk("R1", 3'd7);
      chk("R1", {7'b0, irq}, 8'h00);
      irq_chk("R1", 8'hFF);

      // R2: bank selection keeps per-bank storage
      do_write(3'd7, 8'h03); do_write(3'd2, 8'h5A);
      do_write(3'd7, 8'h04); do_write(3'd2, 8'hA5);
      do_write(3'd7, 8'h03); rd_chk("R2", 3'd2);
      do_write(3'd7, 8'h04); rd_chk("R2", 3'd2);

      // R3: control register layout, reserved bits read zero
      do_write(3'd7, 8'h5D & 8'hBF);
      rd_chk("R3", 3'd7);
      chk("R3", exp_read(3'd7), 8'h05);
      do_write(3'd7, 8'h06); rd_chk("R3", 3'd7);

      // R4: bank 0 map, status read-only and sticky
      do_write(3'd7, 8'h00);
      do_write(3'd0, 8'hFF); rd_chk("R4", 3'd0);
      pulse_evt(8'h11); rd_chk("R4", 3'd0);
      pulse_evt(8'h02); rd_chk("R4", 3'd0);
      do_write(3'd5, 8'h77); rd_chk("R4", 3'd5); rd_chk("R4", 3'd6);
      do_write(3'd1, 8'h0F); do_write(3'd2, 8'h21);
      do_write(3'd3, 8'h32); do_write(3'd4, 8'h43);
      rd_chk("R4", 3'd1); rd_chk("R4", 3'd2); rd_chk("R4", 3'd3); rd_chk("R4", 3'd4);

      // R6: error clear
      do_write(3'd7, 8'h10);
      rd_chk("R6", 3'd0); rd_chk("R6", 3'd2); rd_chk("R6", 3'd3);
      rd_chk("R6", 3'd4); rd_chk("R6", 3'd1);
      chk("R6", exp_read(3'd1), 8'h0F);

      // R7: interrupt gating
      irq_chk("R7", 8'h01);
      do_write(3'd7, 8'h20);
      irq_chk("R7", 8'h01); irq_chk("R7", 8'hF0); irq_chk("R7", 8'h08);
      irq_req = '0;

      // R5: bank 1 map
      do_write(3'd7, 8'h01);
      do_write(3'd0, 8'hFF); do_write(3'd1, 8'h33); do_write(3'd6, 8'h66);
      rd_chk("R5", 3'd0); rd_chk("R5", 3'd1); rd_chk("R5", 3'd6);

      // R9: power down blocks the window only
      do_write(3'd7, 8'h81);
      rd_chk("R9", 3'd1);
      do_write(3'd1, 8'h99);
      rd_chk("R9", 3'd7);
      do_write(3'd7, 8'h01);
      rd_chk("R9", 3'd1);
      chk("R9", exp_read(3'd1), 8'h33);

      // R10: deselected writes ignored, idle rdata zero
      @(negedge clk);
      cs_n = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 8'hEE; rd = 1'b1;
      #1 chk("R10", rdata, 8'h00);
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      rd_chk("R10", 3'd1);

      // R8: soft reset with preserved registers
      do_write(3'd7, 8'h05); do_write(3'd3, 8'hC3);
      do_write(3'd7, 8'h00); do_write(3'd1, 8'hFF); pulse_evt(8'h80);
      do_write(3'd7, 8'hE1);
      do_write(3'd7, 8'h40);
      rd_chk("R8", 3'd7);
      chk("R8", exp_read(3'd7), 8'h00);
      sweep("R8");
      do_write(3'd7, 8'h01);
      chk("R8", exp_read(3'd0), 8'h7F);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         logic [7:0] d;
         op = int'($urandom % 5);
         d  = 8'($urandom);
         case (op)
            0: begin
               if ($urandom % 12 != 0) d[6] = 1'b0;
               d[7] = ($urandom % 4 == 0);
               do_write(3'd7, d);
            end
            1: do_write(3'($urandom % 7), d);
            2: rd_chk("R2", 3'($urandom % 8));
            3: irq_chk("R7", d);
            default: pulse_evt(d & 8'($urandom));
         endcase
      end
      irq_req = '0;
      do_write(3'd7, 8'h00);
      sweep("R2");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule